// File: doc/BRIEF.md
# Match Vector Count and Iterator

This block sits behind the compare array of a multiple-match content addressable memory. It accepts the 64-bit vector of per-entry hits from one search, reports how many entries hit, and then lists the hit addresses one at a time as a 6-bit encoded address. The lowest hit address appears without any request. Each pulse on the step input moves the output to the next higher hit address. The compare itself is not part of this block.

A search result is accepted on a clock edge where `hit_vld` is high. The count, the first address and the valid flag are registered on that edge, so they are visible one clock after the result is presented. Stepping may start in the very cycle that these first results appear, and the first step is expected there or one cycle later. The block keeps a working copy of the vector and clears the bit of each address once it has been shown. The next address comes from a lowest-set-bit priority encoder run over that copy.

The sequencer has three named states. ST_IDLE holds from reset until the first search. ST_WALK holds while a valid address is on the output. ST_DRAINED holds after a miss, or after a step past the last hit. A search moves any state to ST_WALK on a hit and to ST_DRAINED on a miss. A step in ST_WALK stays in ST_WALK while further hits remain and goes to ST_DRAINED when none remain. Steps in ST_IDLE and ST_DRAINED are ignored.

Top module: `hit_walker`

## Requirements
- R1: After reset, hit_cnt is 0, hit_addr is 0 and addr_vld is 0.
- R2: On the clock edge after a cycle with hit_vld high, hit_cnt equals the number of ones in hit_vec, from 0 up to 64 (7 bits wide).
- R3: On that same edge, with no step, hit_addr shows the lowest index whose hit_vec bit is 1, and addr_vld is high.
- R4: While addr_vld is high, a step sampled on a clock edge moves hit_addr to the next higher set index of the searched vector. This holds from the first cycle the results are visible, so the addresses are visited in ascending order, each once.
- R5: A step taken when the shown address is the last hit leaves hit_addr unchanged and drives addr_vld low. Further steps change no output.
- R6: A search with an all-zero hit_vec gives hit_cnt 0 and addr_vld 0.
- R7: In cycles with neither hit_vld nor step, hit_cnt, hit_addr and addr_vld hold their values, whatever hit_vec carries. hit_cnt also holds while stepping.
- R8: When hit_vld and step are high together, the new search takes effect and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vec | input | 64 | Per-entry hit vector from the compare array |
| hit_vld | input | 1 | hit_vec carries a new search result this cycle |
| step | input | 1 | Request to advance to the next hit address |
| hit_cnt | output | 7 | Number of entries that hit |
| hit_addr | output | 6 | Encoded address of the current hit |
| addr_vld | output | 1 | hit_addr names an unvisited hit |

## Verification
The bench walks a sparse three-hit vector, a full vector of 64 hits and a vector with only the top bit set. A design with an off-by-one in the encoder, or a count that wraps at 64 in a 6-bit field, shows a wrong address or a count of 0. It steps past the last hit and keeps stepping. A design that cleared the address, or that wrapped back to the first hit, would be caught there. It also issues a search together with a step, which shows whether a design let the stale step skip the first address of the new result. It also changes hit_vec while hit_vld is low, which exposes a design that samples the vector without the strobe.

// File: rtl/hit_walker_pkg.sv
package hit_walker_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WALK    = 2'd1,
        ST_DRAINED = 2'd2
    } walk_state_e;
endpackage

// File: rtl/hw_popcount.sv
module hw_popcount #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] part [W+1];

    assign part[0] = '0;
    generate
        for (genvar g = 0; g < W; g++) begin : g_acc
            assign part[g+1] = part[g] + CW'(vec[g]);
        end
    endgenerate
    assign cnt = part[W];
endmodule

// File: rtl/hw_lowbit.sv
module hw_lowbit #(
    parameter int W  = 64,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [AW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/hit_walker.sv
module hit_walker
    import hit_walker_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int AW = $clog2(ENTRIES),
    localparam int CW = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic               hit_vld,
    input  logic               step,
    output logic [CW-1:0]      hit_cnt,
    output logic [AW-1:0]      hit_addr,
    output logic               addr_vld
);
    walk_state_e        state_q, state_d;
    logic [ENTRIES-1:0] rem_q;
    logic [ENTRIES-1:0] rem_less;
    logic [ENTRIES-1:0] enc_src;
    logic [AW-1:0]      enc_idx;
    logic               enc_any;
    logic [CW-1:0]      pop;
    logic               adv;

    assign rem_less = rem_q & ~({{(ENTRIES-1){1'b0}}, 1'b1} << hit_addr);
    assign enc_src  = hit_vld ? hit_vec : rem_less;
    assign adv      = step && !hit_vld && (state_q == ST_WALK);

    hw_lowbit #(.W(ENTRIES), .AW(AW)) u_enc (
        .vec (enc_src),
        .idx (enc_idx),
        .any (enc_any)
    );

    hw_popcount #(.W(ENTRIES), .CW(CW)) u_pop (
        .vec (hit_vec),
        .cnt (pop)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit_vld) state_d = enc_any ? ST_WALK : ST_DRAINED;
            end
            ST_WALK: begin
                if (hit_vld || step) state_d = enc_any ? ST_WALK : ST_DRAINED;
            end
            ST_DRAINED: begin
                if (hit_vld) state_d = enc_any ? ST_WALK : ST_DRAINED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            hit_cnt  <= '0;
            hit_addr <= '0;
            addr_vld <= 1'b0;
        end else if (hit_vld) begin
            rem_q    <= hit_vec;
            hit_cnt  <= pop;
            hit_addr <= enc_any ? enc_idx : '0;
            addr_vld <= enc_any;
        end else if (adv) begin
            rem_q    <= rem_less;
            addr_vld <= enc_any;
            if (enc_any) hit_addr <= enc_idx;
        end
    end

    // R2
    cnt_nonzero_when_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |-> (hit_cnt != '0));

    // R4
    ascending_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit_vld && addr_vld) |=> (!addr_vld || (hit_addr > $past(hit_addr))));

    // R5
    hold_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit_vld) |=> (addr_vld || $stable(hit_addr)));

    // R6
    miss_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vld && (hit_vec == '0)) |=> (!addr_vld && (hit_cnt == '0)));

    // R7
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_vld && !step) |=> ($stable(hit_cnt) && $stable(hit_addr) && $stable(addr_vld)));

    // R7
    cnt_steady_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vld |=> $stable(hit_cnt));
endmodule

// File: tb/hit_walker_bench.sv
`timescale 1ns/1ps
module hit_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] hit_vec = '0;
    logic        hit_vld = 1'b0;
    logic        step = 1'b0;
    logic [6:0]  hit_cnt;
    logic [5:0]  hit_addr;
    logic        addr_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hit_walker u_hit_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_vec),
        .hit_vld  (hit_vld),
        .step     (step),
        .hit_cnt  (hit_cnt),
        .hit_addr (hit_addr),
        .addr_vld (addr_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic search(input logic [63:0] v, input logic with_step);
        @(negedge clk);
        hit_vec = v; hit_vld = 1'b1; step = with_step;
        @(negedge clk);
        hit_vld = 1'b0; step = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    // Search, then walk every hit in ascending order and step once past the end.
    task automatic walk_vector(input logic [63:0] v, input string tag);
        int last;
        int first;
        search(v, 1'b0);
        chk({tag, " R2 count"}, hit_cnt, $countones(v));
        first = -1;
        for (int i = 0; i < 64; i++) if (v[i] && first < 0) first = i;
        if (first < 0) begin
            chk({tag, " R6 vld"}, addr_vld, 0);
            return;
        end
        chk({tag, " R3 first addr"}, hit_addr, first);
        chk({tag, " R3 vld"}, addr_vld, 1);
        last = first;
        for (int i = first + 1; i < 64; i++) begin
            if (v[i]) begin
                do_step();
                chk({tag, " R4 next addr"}, hit_addr, i);
                chk({tag, " R4 vld"}, addr_vld, 1);
                last = i;
            end
        end
        do_step();
        chk({tag, " R5 addr held"}, hit_addr, last);
        chk({tag, " R5 vld low"}, addr_vld, 0);
        chk({tag, " R7 count held"}, hit_cnt, $countones(v));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 cnt", hit_cnt, 0);
        chk("R1 addr", hit_addr, 0);
        chk("R1 vld", addr_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sparse();
        logic [63:0] v = '0;
        v[0] = 1'b1; v[8] = 1'b1; v[16] = 1'b1;
        walk_vector(v, "sparse");
    endtask

    task automatic t_full();
        walk_vector({64{1'b1}}, "full");
    endtask

    task automatic t_top_only();
        walk_vector(64'h8000_0000_0000_0000, "top");
    endtask

    task automatic t_miss();
        walk_vector('0, "miss");
        do_step();
        chk("R6 step on miss vld", addr_vld, 0);
        chk("R6 step on miss cnt", hit_cnt, 0);
    endtask

    task automatic t_overrun();
        search(64'h0000_0000_0000_0220, 1'b0);
        do_step();
        do_step();
        chk("R5 overrun addr", hit_addr, 9);
        chk("R5 overrun vld", addr_vld, 0);
        do_step();
        do_step();
        chk("R5 extra steps addr", hit_addr, 9);
        chk("R5 extra steps vld", addr_vld, 0);
        chk("R5 extra steps cnt", hit_cnt, 2);
    endtask

    task automatic t_hold();
        search(64'h0000_0000_0000_0204, 1'b0);
        @(negedge clk);
        hit_vec = 64'hFFFF_0000_FFFF_0001;
        repeat (3) @(negedge clk);
        chk("R7 hold addr", hit_addr, 2);
        chk("R7 hold cnt", hit_cnt, 2);
        chk("R7 hold vld", addr_vld, 1);
        do_step();
        chk("R4 after idle gap", hit_addr, 9);
    endtask

    task automatic t_collide();
        search(64'h0000_0000_0000_0028, 1'b0);
        search(64'h0000_0000_0000_8400, 1'b1);
        chk("R8 new cnt", hit_cnt, 2);
        chk("R8 first addr not skipped", hit_addr, 10);
        chk("R8 vld", addr_vld, 1);
        do_step();
        chk("R8 then step", hit_addr, 15);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_sparse();
        t_full();
        t_top_only();
        t_miss();
        t_overrun();
        t_hold();
        t_collide();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule